// File: doc/BRIEF.md
# Shared-Prescaler Timer Tick Generator

This block derives the count-enable ticks for a five-channel timer from one system clock. Two programmable 8-bit prescalers each serve a group of channels. Channels 0 and 1 hang off the first prescaler. Channels 2, 3 and 4 hang off the second.

Every channel has a 4-bit selector. The selector either divides its group's prescaled tick stream by a fixed power of two (2, 4, 8 or 16), or passes through the rising edges of an external timer clock. That external clock is first synchronised into the system clock domain.

The outputs are single-cycle enable pulses, one per channel, all in the system clock domain. The block produces no gated or derived clocks. The timer counters consume these pulses as count enables.

Top module: `tcg_clk_tree`

## Requirements
- R1: While rst_ni is low, every bit of tick_o is 0.
- R2: A prescaler value N divides the system clock by N+1. A channel in divider mode therefore pulses every (N+1)*2^(k+1) cycles.
- R3: Selector value k in 0..3 divides that channel's prescaled tick stream by 2^(k+1), giving 2, 4, 8 or 16.
- R4: Channels 0 and 1 use the prescaler value in psc_cfg_i[7:0]. Channels 2, 3 and 4 use the value in psc_cfg_i[15:8].
- R5: Selector value 4 makes the channel pulse once per rising edge of an external clock, after a two-flop synchronizer. ext_clk_i[0] serves channels 0 and 1, and ext_clk_i[1] serves channels 2 to 4. Selector values 5 to 15 behave exactly like 4.
- R6: The selector for channel n is sel_cfg_i[4n+3:4n]. Each channel's output depends only on its own field, so different channels run at different rates at the same time.
- R7: A prescaler value of 0 passes every system clock cycle through as a prescaled tick, so a divider-mode channel pulses every 2^(k+1) cycles.
- R8: Any change of a prescaler value restarts that prescaler's count from zero. The first prescaled tick after the change comes a full new period (N+1 cycles) after the cycle in which the change is taken.
- R9: Each tick_o bit is high for exactly one cycle at a time and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psc_cfg_i | input | 16 | Prescaler values: group 0 in [7:0], group 1 in [15:8] |
| sel_cfg_i | input | 20 | Per-channel 4-bit source/divide selectors, channel n at bit 4n |
| ext_clk_i | input | 2 | External timer clocks: [0] for group 0, [1] for group 1 |
| tick_o | output | 5 | Single-cycle count-enable pulse per channel |

## Verification
A wrong prescaler count or a missed restart shows up as a tick spacing that departs from (N+1)*2^(k+1). That departure is visible within one channel period, or within 2*(N+1) cycles after a prescaler change. A divider counter decoded with the wrong mask gives a wrong interval on the very next tick. A wrong group or field mapping changes the interval of a neighbouring channel in the same measurement window. The bench measures the minimum and maximum interval between ticks on every channel at once, and so detects any of these faults within a few periods.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  // Selector codes at or above this value route the external clock.
  localparam int unsigned SEL_EXT = 4;
endpackage

// File: rtl/tcg_prescaler.sv
module tcg_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PSC_W-1:0] val_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] val_q;
  logic [PSC_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (val_i != val_q) begin
      // new value: restart the period
      val_q  <= val_i;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == val_q) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= val_q);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (val_i != val_q) |=> (!tick_o && cnt_q == '0));
endmodule

// File: rtl/tcg_ext_sync.sv
module tcg_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ext_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];

  p_rise_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tcg_chan_div.sv
module tcg_chan_div
  import tcg_pkg::*;
#(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psc_tick_i,
  input  logic             ext_rise_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned KW = (DIV_W > 1) ? $clog2(DIV_W) : 1;

  logic             is_ext;
  logic [KW-1:0]    k;
  logic [DIV_W-1:0] mask;
  logic [DIV_W-1:0] div_cnt_q;
  logic             div_hit;
  logic             tick_q;

  assign is_ext = (sel_i >= SEL_W'(SEL_EXT));
  assign k      = sel_i[KW-1:0];

  // low k+1 bits of the divider take part in the terminal count
  always_comb begin
    for (int i = 0; i < DIV_W; i++) mask[i] = (i <= int'(k));
  end

  assign div_hit = psc_tick_i & (&(div_cnt_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      tick_q    <= 1'b0;
    end else begin
      if (psc_tick_i) div_cnt_q <= div_cnt_q + 1'b1;
      tick_q <= is_ext ? ext_rise_i : div_hit;
    end
  end

  assign tick_o = tick_q;

  p_single_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  p_div_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(is_ext)) |-> $past(psc_tick_i));

  p_ext_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(is_ext)) |-> $past(ext_rise_i));
endmodule

// File: rtl/tcg_clk_tree.sv
module tcg_clk_tree #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned G0_CH  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2*PSC_W-1:0]       psc_cfg_i,
  input  logic [NUM_CH*SEL_W-1:0]  sel_cfg_i,
  input  logic [1:0]               ext_clk_i,
  output logic [NUM_CH-1:0]        tick_o
);
  localparam int unsigned NUM_GRP = 2;

  logic [NUM_GRP-1:0] psc_tick;
  logic [NUM_GRP-1:0] ext_rise;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    tcg_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (psc_cfg_i[g*PSC_W +: PSC_W]),
      .tick_o (psc_tick[g])
    );
    tcg_ext_sync u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ext_i  (ext_clk_i[g]),
      .rise_o (ext_rise[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned GRP = (c < G0_CH) ? 0 : 1;
    tcg_chan_div #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_div (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .psc_tick_i (psc_tick[GRP]),
      .ext_rise_i (ext_rise[GRP]),
      .sel_i      (sel_cfg_i[c*SEL_W +: SEL_W]),
      .tick_o     (tick_o[c])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (tick_o == '0 || rst_ni));
endmodule

// File: tb/tcg_clk_tree_tb_top.sv
module tcg_clk_tree_tb_top;
  localparam int NCH = 5;
  localparam int EXT0_P = 10;
  localparam int EXT1_P = 14;
  localparam int NV = 5;
  // {psc1, psc0, sel4, sel3, sel2, sel1, sel0}
  localparam logic [35:0] VEC [NV] = '{
    {8'd0,   8'd0,   4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
    {8'd4,   8'd2,   4'd0, 4'd3, 4'd2, 4'd1, 4'd0},
    {8'd0,   8'd1,   4'd15,4'd9, 4'd0, 4'd4, 4'd3},
    {8'd3,   8'd7,   4'd2, 4'd3, 4'd4, 4'd0, 4'd1},
    {8'd1,   8'd255, 4'd4, 4'd0, 4'd1, 4'd2, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] psc_cfg = '0;
  logic [19:0] sel_cfg = '0;
  logic [1:0]  ext_clk = '0;
  logic [4:0]  tick;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit mon_clr = 1'b0;
  int last_t [NCH], cnt_t [NCH], min_iv [NCH], max_iv [NCH];

  tcg_clk_tree dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .psc_cfg_i(psc_cfg), .sel_cfg_i(sel_cfg),
    .ext_clk_i(ext_clk), .tick_o(tick)
  );

  always #5 clk = ~clk;
  initial begin #3; forever #(EXT0_P*5) ext_clk[0] = ~ext_clk[0]; end
  initial begin #3; forever #(EXT1_P*5) ext_clk[1] = ~ext_clk[1]; end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NCH; c++) begin
      if (mon_clr) begin
        cnt_t[c] <= 0; min_iv[c] <= 1 << 30; max_iv[c] <= 0;
      end else if (tick[c]) begin
        if (cnt_t[c] > 0) begin
          if (cyc - last_t[c] < min_iv[c]) min_iv[c] <= cyc - last_t[c];
          if (cyc - last_t[c] > max_iv[c]) max_iv[c] <= cyc - last_t[c];
        end
        last_t[c] <= cyc;
        cnt_t[c]  <= cnt_t[c] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int c, input logic [15:0] p, input logic [19:0] s);
    int n, k;
    k = int'(s[c*4 +: 4]);
    if (k >= 4) return (c < 2) ? EXT0_P : EXT1_P;
    n = (c < 2) ? int'(p[7:0]) : int'(p[15:8]);
    return (n + 1) * (2 << k);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 190000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=0", wd);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int maxp, dt, t0;
    // R1: quiet during reset
    wait_cyc(4);
    check(tick == '0, "R1", int'(tick), 0);
    @(posedge clk); #1 rst_ni = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      @(posedge clk); #1;
      psc_cfg = VEC[v][35:20];
      sel_cfg = VEC[v][19:0];
      maxp = 0;
      for (int c = 0; c < NCH; c++)
        if (exp_period(c, psc_cfg, sel_cfg) > maxp) maxp = exp_period(c, psc_cfg, sel_cfg);
      wait_cyc(2 * maxp + 10);
      clear_mon();
      wait_cyc(3 * maxp + 10);
      for (int c = 0; c < NCH; c++) begin
        check(cnt_t[c] >= 3, "R6 tick count", cnt_t[c], 3);
        check(min_iv[c] == exp_period(c, psc_cfg, sel_cfg),
              (v == 0) ? "R7 min interval" : "R2/R3/R4/R5 min interval",
              min_iv[c], exp_period(c, psc_cfg, sel_cfg));
        check(max_iv[c] == exp_period(c, psc_cfg, sel_cfg), "R9 R2 max interval",
              max_iv[c], exp_period(c, psc_cfg, sel_cfg));
      end
    end

    // R8: restart on prescaler change, channel 0 at /2
    @(posedge clk); #1;
    psc_cfg = {8'd0, 8'd200};
    sel_cfg = '0;
    wait_cyc(900);
    while (!tick[0]) @(negedge clk);
    wait_cyc(140);
    @(posedge clk); #1 psc_cfg = {8'd0, 8'd10};
    t0 = cyc;
    @(negedge clk);
    while (!tick[0] && (cyc - t0) < 400) @(negedge clk);
    dt = cyc - t0;
    check(dt >= 11 && dt <= 25, "R8 first tick after change", dt, 23);
    clear_mon();
    wait_cyc(80);
    check(min_iv[0] == 22 && max_iv[0] == 22, "R8 new period", min_iv[0], 22);

    // R1: reset again mid-run clears outputs
    @(posedge clk); #1 rst_ni = 1'b0;
    wait_cyc(3);
    check(tick == '0, "R1 re-reset", int'(tick), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule